// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps every dispatched instruction in a circular buffer, oldest entry at the head and youngest at the tail. Each entry holds the destination logical register, the physical tag allocated for it, the tag it replaced, the PC and two status bits: complete and faulted. Execution units report completion by entry index in any order. The entry at the head retires once it is complete and has no fault. Retirement drives the commit outputs, which the rename block uses to update its committed map and to free the replaced tag.

A fault is acted on only after the faulting entry reaches the head and is complete. In that cycle the buffer raises its exception output with the entry's PC, retires nothing, and discards all entries at the next edge. A branch misprediction works differently. The cycle a branch completes as mispredicted, the block raises its branch-flush output and drops every entry younger than the branch at the next edge. The branch stays in the buffer and retires normally. Exception service and refetch belong to other blocks.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `commit_valid`, `exc_valid` and `brflush_valid` are low, `disp_ready` is high and `disp_idx` is 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. It takes the entry shown on `disp_idx`, which is the tail. Successive dispatches get consecutive indices modulo DEPTH.
- R3: `disp_ready` is low while DEPTH entries are held. A dispatch offered then is ignored and does not move the tail.
- R4: Completions arrive by index in any order. Retirement happens only from the head, at most one entry per cycle, in dispatch order, and only for an entry that is complete and has no fault. `commit_lreg`, `commit_new_tag` and `commit_old_tag` carry the retiring entry's dispatch fields.
- R5: When the head entry is complete and faulted, `exc_valid` is high for that cycle and `exc_pc` carries that entry's PC. At the next edge the buffer becomes empty, and the next dispatch gets the faulting entry's index.
- R6: A faulted entry raises no exception while any older entry is incomplete. Entries younger than a faulted entry never retire.
- R7: A completion with `cmpl_mispred` high raises `brflush_valid` in the same cycle. At the next edge all entries younger than the branch are dropped and the tail moves to the branch index plus one. The branch and all older entries still retire.
- R8: A misprediction flush recomputes the occupancy. If the branch is the youngest entry of a full buffer, the buffer stays full. If younger entries are dropped, `disp_ready` rises again.
- R9: A completion whose index lies outside the occupied range has no effect. This includes a stale mispredict, which raises no `brflush_valid` and does not move the tail.
- R10: `disp_ready` is low in any cycle in which `exc_valid` or `brflush_valid` is high.
- R11: `commit_valid` and `exc_valid` are never high together. When the head raises an exception, a mispredict completion in the same cycle is ignored and `brflush_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | $clog2(DEPTH) | Entry index the next dispatch receives |
| disp_lreg | input | LREG_W | Destination logical register |
| disp_new_tag | input | PTAG_W | Physical tag allocated to the destination |
| disp_old_tag | input | PTAG_W | Physical tag previously mapped to the destination |
| disp_pc | input | PC_W | Instruction PC |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | $clog2(DEPTH) | Entry index being completed |
| cmpl_exc | input | 1 | Completing entry faulted |
| cmpl_mispred | input | 1 | Completing entry is a mispredicted branch |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_lreg | output | LREG_W | Retiring logical register |
| commit_new_tag | output | PTAG_W | Retiring physical tag |
| commit_old_tag | output | PTAG_W | Tag freed by the retirement |
| exc_valid | output | 1 | Head entry faulted; buffer clears at next edge |
| exc_pc | output | PC_W | PC of the faulting head entry |
| brflush_valid | output | 1 | Younger entries are dropped at next edge |

## Verification
Completions are driven in several orders: ascending from a non-head entry, fully reversed over a wrapped full buffer, and head-last. These show that retirement waits on the head alone and still drains in dispatch order. Faults are placed behind an incomplete older entry and also at the head while a younger branch completes mispredicted, which separates deferral from priority. Mispredicts are applied in the middle of the buffer, at the youngest entry of a full buffer, and to an already flushed index. These three cases separate tail rewind, occupancy recomputation and the range check.

// File: rtl/reorder_buf_pkg.sv
// Package: shared types for the retirement buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package reorder_buf_pkg;

    // What the head entry does in a cycle
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_RETIRE = 2'd1,
        ACT_TRAP   = 2'd2
    } head_act_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
// Module: head/tail pointers and occupancy count of the circular buffer.
// Does: advances head on retire, tail on allocate; rewinds tail on a
// mispredict squash and empties the buffer on a trap.
// Assumes: DEPTH is a power of two; trap and squash are never both high.
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             retire,
    input  logic             trap,
    input  logic             squash,
    input  logic [IDX_W-1:0] sq_idx,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    logic [IDX_W-1:0] sq_dist;
    logic [CNT_W-1:0] sq_count;

    // Entries kept by a squash: the branch and everything older
    always_comb begin
        sq_dist  = sq_idx - head;
        sq_count = {1'b0, sq_dist} + CNT_W'(1) - CNT_W'(retire);
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (trap) begin
            tail  <= head;
            count <= '0;
        end else begin
            head <= head + IDX_W'(retire);
            if (squash) begin
                tail  <= sq_idx + IDX_W'(1);
                count <= sq_count;
            end else begin
                tail  <= tail + IDX_W'(alloc);
                count <= count + CNT_W'(alloc) - CNT_W'(retire);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R3
    AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (count == '0) && (tail == head)); // R5
    AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> tail == $past(sq_idx) + IDX_W'(1)); // R7
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !trap) |=> head == $past(head) + IDX_W'(1)); // R4

endmodule

// File: rtl/rob_entry_store.sv
// Module: per-entry storage of the buffer.
// Does: writes dispatch fields at the tail, sets complete/fault flags by
// index, presents the head entry.
// Assumes: alloc and cmpl_hit never target the same entry in one cycle.
module rob_entry_store #(
    parameter int DEPTH  = 8,
    parameter int LREG_W = 5,
    parameter int PTAG_W = 6,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  tail,
    input  logic [LREG_W-1:0] wr_lreg,
    input  logic [PTAG_W-1:0] wr_new_tag,
    input  logic [PTAG_W-1:0] wr_old_tag,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic              cmpl_hit,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              cmpl_exc,
    input  logic [IDX_W-1:0]  head,
    output logic [LREG_W-1:0] rd_lreg,
    output logic [PTAG_W-1:0] rd_new_tag,
    output logic [PTAG_W-1:0] rd_old_tag,
    output logic [PC_W-1:0]   rd_pc,
    output logic              rd_done,
    output logic              rd_exc
);

    logic [LREG_W-1:0] lreg_a [DEPTH];
    logic [PTAG_W-1:0] newt_a [DEPTH];
    logic [PTAG_W-1:0] oldt_a [DEPTH];
    logic [PC_W-1:0]   pc_a   [DEPTH];
    logic [DEPTH-1:0]  done_v;
    logic [DEPTH-1:0]  exc_v;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [LREG_W-1:0] e_lreg;
        logic [PTAG_W-1:0] e_newt;
        logic [PTAG_W-1:0] e_oldt;
        logic [PC_W-1:0]   e_pc;
        logic              e_done;
        logic              e_exc;
        logic              wr_sel;
        logic              cp_sel;

        // Decode whether this entry is written this cycle
        always_comb begin
            wr_sel = alloc && (tail == IDX_W'(i));
            cp_sel = cmpl_hit && (cmpl_idx == IDX_W'(i));
        end

        // Entry state: fields on allocate, flags on completion
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_lreg <= '0;
                e_newt <= '0;
                e_oldt <= '0;
                e_pc   <= '0;
                e_done <= 1'b0;
                e_exc  <= 1'b0;
            end else if (wr_sel) begin
                e_lreg <= wr_lreg;
                e_newt <= wr_new_tag;
                e_oldt <= wr_old_tag;
                e_pc   <= wr_pc;
                e_done <= 1'b0;
                e_exc  <= 1'b0;
            end else if (cp_sel) begin
                e_done <= 1'b1;
                e_exc  <= cmpl_exc;
            end
        end

        assign lreg_a[i]  = e_lreg;
        assign newt_a[i]  = e_newt;
        assign oldt_a[i]  = e_oldt;
        assign pc_a[i]    = e_pc;
        assign done_v[i]  = e_done;
        assign exc_v[i]   = e_exc;
    end

    // Head read port
    always_comb begin
        rd_lreg    = lreg_a[head];
        rd_new_tag = newt_a[head];
        rd_old_tag = oldt_a[head];
        rd_pc      = pc_a[head];
        rd_done    = done_v[head];
        rd_exc     = exc_v[head];
    end

    AST_CMPL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_hit |=> done_v[$past(cmpl_idx)]); // R4
    AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> !done_v[$past(tail)]); // R2

endmodule

// File: rtl/rob_retire_ctrl.sv
// Module: decides the head action and screens completions and dispatches.
// Does: retire/trap choice, range check of completion indices, squash
// request, dispatch acceptance.
// Assumes: count and head come from rob_ptr_ctrl.
module rob_retire_ctrl
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] head,
    input  logic             head_done,
    input  logic             head_exc,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_idx,
    input  logic             cmpl_mispred,
    input  logic             disp_valid,
    output head_act_e        act,
    output logic             cmpl_hit,
    output logic             squash,
    output logic             disp_ready,
    output logic             alloc
);

    logic [IDX_W-1:0] cmpl_off;
    logic             in_range;
    logic             full;
    logic             trap;

    // Head action: retire clean completed entry, trap faulted one
    always_comb begin
        act = ACT_IDLE;
        if (count != '0 && head_done)
            act = head_exc ? ACT_TRAP : ACT_RETIRE;
        trap = (act == ACT_TRAP);
    end

    // Completion screening and squash request
    always_comb begin
        cmpl_off = cmpl_idx - head;
        in_range = {1'b0, cmpl_off} < count;
        cmpl_hit = cmpl_valid && in_range && !trap;
        squash   = cmpl_hit && cmpl_mispred;
    end

    // Dispatch acceptance
    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        disp_ready = !full && !trap && !squash;
        alloc      = disp_valid && disp_ready;
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act == ACT_RETIRE, act == ACT_TRAP})); // R11
    AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !alloc); // R3
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (squash || act == ACT_TRAP) |-> !alloc); // R10

endmodule

// File: rtl/reorder_buf.sv
// Module: top of the in-order retirement buffer.
// Does: ties pointer control, entry storage and head control together and
// drives dispatch, commit, exception and branch-flush ports.
// Assumes: DEPTH is a power of two of at least 2; completions name entries
// that are in flight.
module reorder_buf
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LREG_W = 5,
    parameter int PTAG_W = 6,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic [LREG_W-1:0] disp_lreg,
    input  logic [PTAG_W-1:0] disp_new_tag,
    input  logic [PTAG_W-1:0] disp_old_tag,
    input  logic [PC_W-1:0]   disp_pc,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              cmpl_exc,
    input  logic              cmpl_mispred,
    output logic              commit_valid,
    output logic [LREG_W-1:0] commit_lreg,
    output logic [PTAG_W-1:0] commit_new_tag,
    output logic [PTAG_W-1:0] commit_old_tag,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    output logic              brflush_valid
);

    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [CNT_W-1:0] count;
    logic             head_done;
    logic             head_exc;
    logic [PC_W-1:0]  head_pc;
    head_act_e        act;
    logic             cmpl_hit;
    logic             squash;
    logic             alloc;
    logic             retire;
    logic             trap;

    // Decode head action into control strobes
    always_comb begin
        retire = (act == ACT_RETIRE);
        trap   = (act == ACT_TRAP);
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (alloc),
        .retire (retire),
        .trap   (trap),
        .squash (squash),
        .sq_idx (cmpl_idx),
        .head   (head),
        .tail   (tail),
        .count  (count)
    );

    rob_entry_store #(
        .DEPTH (DEPTH), .LREG_W(LREG_W), .PTAG_W(PTAG_W), .PC_W(PC_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .tail       (tail),
        .wr_lreg    (disp_lreg),
        .wr_new_tag (disp_new_tag),
        .wr_old_tag (disp_old_tag),
        .wr_pc      (disp_pc),
        .cmpl_hit   (cmpl_hit),
        .cmpl_idx   (cmpl_idx),
        .cmpl_exc   (cmpl_exc),
        .head       (head),
        .rd_lreg    (commit_lreg),
        .rd_new_tag (commit_new_tag),
        .rd_old_tag (commit_old_tag),
        .rd_pc      (head_pc),
        .rd_done    (head_done),
        .rd_exc     (head_exc)
    );

    rob_retire_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (count),
        .head         (head),
        .head_done    (head_done),
        .head_exc     (head_exc),
        .cmpl_valid   (cmpl_valid),
        .cmpl_idx     (cmpl_idx),
        .cmpl_mispred (cmpl_mispred),
        .disp_valid   (disp_valid),
        .act          (act),
        .cmpl_hit     (cmpl_hit),
        .squash       (squash),
        .disp_ready   (disp_ready),
        .alloc        (alloc)
    );

    // Port drive
    always_comb begin
        disp_idx      = tail;
        commit_valid  = retire;
        exc_valid     = trap;
        exc_pc        = head_pc;
        brflush_valid = squash;
    end

    initial begin
        AST_DEPTH_POW2: assert ((DEPTH >= 2) && ((DEPTH & (DEPTH - 1)) == 0)); // R2
    end

    AST_EXC_NOT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && exc_valid)); // R11
    AST_EXC_NO_BRFLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !brflush_valid); // R11

endmodule

// File: tb/reorder_buf_tb.sv
`timescale 1ns/100ps
module reorder_buf_tb;

    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [2:0]  disp_idx;
    logic [4:0]  disp_lreg = '0;
    logic [5:0]  disp_new_tag = '0;
    logic [5:0]  disp_old_tag = '0;
    logic [31:0] disp_pc = '0;
    logic        cmpl_valid = 1'b0;
    logic [2:0]  cmpl_idx = '0;
    logic        cmpl_exc = 1'b0;
    logic        cmpl_mispred = 1'b0;
    logic        commit_valid;
    logic [4:0]  commit_lreg;
    logic [5:0]  commit_new_tag;
    logic [5:0]  commit_old_tag;
    logic        exc_valid;
    logic [31:0] exc_pc;
    logic        brflush_valid;

    int n_chk = 0;
    int n_bad = 0;
    int n_commit = 0;
    int exp_tail = 0;
    int seq = 0;
    bit mon_on = 1'b0;
    logic [16:0] exp_q [$];
    int          idx_q [$];

    always #2 clk = ~clk;

    reorder_buf #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [16:0] pack_item(input int n);
        return {5'(n), 6'(32 + n), 6'(n)};
    endfunction

    // Driver: dispatch one item, push expectation into scoreboard
    task automatic dispatch(output int idx);
        int n;
        n = seq++;
        disp_valid   = 1'b1;
        disp_lreg    = 5'(n);
        disp_new_tag = 6'(32 + n);
        disp_old_tag = 6'(n);
        disp_pc      = 32'h1000 + 32'(4 * n);
        #0.5;
        chk(disp_ready == 1'b1, "R2 ready", disp_ready, 1);
        chk(int'(disp_idx) == exp_tail, "R2 idx", disp_idx, exp_tail);
        idx = int'(disp_idx);
        exp_q.push_back(pack_item(n));
        idx_q.push_back(idx);
        exp_tail = (exp_tail + 1) % DEPTH;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic complete(input int idx, input bit exc, input bit mis);
        cmpl_valid = 1'b1; cmpl_idx = 3'(idx); cmpl_exc = exc; cmpl_mispred = mis;
        #0.5;
    endtask

    task automatic cmpl_end();
        step();
        cmpl_valid = 1'b0; cmpl_exc = 1'b0; cmpl_mispred = 1'b0;
    endtask

    task automatic drop_after(input int b);
        while (idx_q.size() > 0 && idx_q[$] != b) begin
            void'(idx_q.pop_back());
            void'(exp_q.pop_back());
        end
        exp_tail = (b + 1) % DEPTH;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    // Monitor: compare each retirement with the scoreboard head
    always @(negedge clk) begin
        if (mon_on) begin
            if (commit_valid && exc_valid)
                chk(1'b0, "R11 both", 1, 0);
            if (commit_valid) begin
                n_commit++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected commit", commit_lreg, -1);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    void'(idx_q.pop_front());
                    chk({commit_lreg, commit_new_tag, commit_old_tag} == e, "R4 commit fields",
                        {commit_lreg, commit_new_tag, commit_old_tag}, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ix [8];
        int t;
        idle(3);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk(commit_valid == 0, "R1 commit", commit_valid, 0);
        chk(exc_valid == 0, "R1 exc", exc_valid, 0);
        chk(brflush_valid == 0, "R1 brflush", brflush_valid, 0);
        chk(disp_ready == 1, "R1 ready", disp_ready, 1);
        chk(disp_idx == 0, "R1 idx", disp_idx, 0);
        mon_on = 1'b1;
        step();

        // R4: out-of-order completion, head last
        for (int i = 0; i < 4; i++) dispatch(ix[i]);
        complete(ix[2], 0, 0); chk(commit_valid == 0, "R4 wait head", commit_valid, 0); cmpl_end();
        complete(ix[3], 0, 0); chk(commit_valid == 0, "R4 wait head", commit_valid, 0); cmpl_end();
        complete(ix[1], 0, 0); chk(commit_valid == 0, "R4 wait head", commit_valid, 0); cmpl_end();
        complete(ix[0], 0, 0); cmpl_end();
        idle(6);
        chk(exp_q.size() == 0 && n_commit == 4, "R4 drained", n_commit, 4);

        // R3: full buffer, wrapped, reverse completion
        for (int i = 0; i < 8; i++) dispatch(ix[i]);
        disp_valid = 1'b1;
        #0.5;
        chk(disp_ready == 0, "R3 full", disp_ready, 0);
        step();
        disp_valid = 1'b0;
        for (int i = 7; i >= 0; i--) begin complete(ix[i], 0, 0); cmpl_end(); end
        idle(10);
        #0.5;
        chk(exp_q.size() == 0, "R4 reverse drained", exp_q.size(), 0);
        chk(int'(disp_idx) == exp_tail, "R3 tail unmoved", disp_idx, exp_tail);

        // R5/R6: fault behind incomplete older entry
        for (int i = 0; i < 3; i++) dispatch(ix[i]);
        complete(ix[1], 1, 0); cmpl_end();
        complete(ix[2], 0, 0);
        chk(exc_valid == 0 && commit_valid == 0, "R6 deferred", exc_valid, 0);
        cmpl_end();
        complete(ix[0], 0, 0); cmpl_end();
        t = 0;
        for (int k = 0; k < 6 && t == 0; k++) begin
            #0.5;
            if (exc_valid) begin
                t = 1;
                chk(exc_pc == 32'h1000 + 32'(4 * (seq - 2)), "R5 pc", exc_pc, 32'h1000 + 4 * (seq - 2));
                chk(disp_ready == 0, "R10 trap blocks", disp_ready, 0);
                chk(exp_q.size() == 2, "R6 only older retired", exp_q.size(), 2);
            end
            step();
        end
        chk(t == 1, "R5 exception seen", t, 1);
        exp_q.delete(); idx_q.delete();
        exp_tail = ix[1];
        #0.5;
        chk(commit_valid == 0 && exc_valid == 0, "R5 empty", commit_valid, 0);
        chk(int'(disp_idx) == ix[1], "R5 tail", disp_idx, ix[1]);
        idle(2);
        chk(exp_q.size() == 0, "R6 younger not retired", n_commit, 5 + 8);

        // R7/R9: mispredict mid-buffer, stale completion
        for (int i = 0; i < 5; i++) dispatch(ix[i]);
        complete(ix[1], 0, 1);
        chk(brflush_valid == 1, "R7 brflush", brflush_valid, 1);
        chk(disp_ready == 0, "R10 flush blocks", disp_ready, 0);
        cmpl_end();
        drop_after(ix[1]);
        dispatch(ix[5]);
        complete(ix[3], 0, 1);
        chk(brflush_valid == 0, "R9 stale ignored", brflush_valid, 0);
        cmpl_end();
        #0.5;
        chk(int'(disp_idx) == exp_tail, "R9 tail kept", disp_idx, exp_tail);
        complete(ix[0], 0, 0); cmpl_end();
        complete(ix[5], 0, 0); cmpl_end();
        idle(6);
        chk(exp_q.size() == 0, "R7 survivors retired", exp_q.size(), 0);

        // R8: flush in a full buffer
        for (int i = 0; i < 8; i++) dispatch(ix[i]);
        complete(ix[7], 0, 1); cmpl_end();
        #0.5;
        chk(disp_ready == 0, "R8 still full", disp_ready, 0);
        complete(ix[5], 0, 1); cmpl_end();
        drop_after(ix[5]);
        #0.5;
        chk(disp_ready == 1, "R8 space freed", disp_ready, 1);
        chk(int'(disp_idx) == exp_tail, "R8 tail", disp_idx, exp_tail);
        for (int i = 0; i < 5; i++) begin complete(ix[i], 0, 0); cmpl_end(); end
        idle(8);
        chk(exp_q.size() == 0, "R8 older retired", exp_q.size(), 0);

        // R11: exception wins over a same-cycle mispredict
        dispatch(ix[0]);
        dispatch(ix[1]);
        complete(ix[0], 1, 0); cmpl_end();
        #0.5;
        chk(exc_valid == 1, "R11 exc", exc_valid, 1);
        complete(ix[1], 0, 1);
        chk(brflush_valid == 0, "R11 brflush suppressed", brflush_valid, 0);
        cmpl_end();
        exp_q.delete(); idx_q.delete();
        exp_tail = ix[0];
        #0.5;
        chk(commit_valid == 0 && exc_valid == 0, "R11 empty", exc_valid, 0);
        chk(int'(disp_idx) == ix[0], "R11 tail", disp_idx, ix[0]);
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule